// File: doc/BRIEF.md
# Expansion-Board 16-bit Memory Window Slave

This block is the memory-slave front end of an expansion board on the classic 16-bit PC expansion bus. It recognises memory cycles that fall inside a programmable window of the 16 MB space, tells the host early that the board can take a 16-bit transfer, stretches or shortens the cycle as configured, routes bytes between the two data-bus halves and an internal word-wide RAM, and stays silent during memory refresh.

The window is defined by an inclusive range of the seven upper address lines, so each step is 128 KB. Those lines are only meaningful while the address-latch strobe is high. The block therefore decodes them straight from the pins while the strobe is high and freezes the decode, together with the low address bits and the high-byte enable, on the cycle the strobe falls. The 16-bit capability flag is driven from the live decode while the strobe is high and from the frozen decode afterwards. A `cfg_wide` bit makes the board look 8-bit only. A zero-wait bit selects the fast response, and a counter sets the number of not-ready cycles for the slow one.

The cycle controller has four states. IDLE waits for a command. WAIT holds ready low while a counter runs. XFER is the single cycle in which a write is stored and zero-wait is signalled. HOLD keeps read data on the bus until the command is released. The transitions are: IDLE→WAIT on an accepted command in slow mode with a non-zero count; IDLE→XFER on an accepted command in zero-wait mode or with a count of zero; WAIT→XFER when the count runs out; WAIT→IDLE if the command is withdrawn; XFER→HOLD always; HOLD→IDLE when both commands are high.

Top module: `isa_mem_slave`

## Requirements
- R1: After reset, `memcs16_n`, `zws_n` and `rdy` are 1 and `sd_oe` is 2'b00.
- R2: While `bale` is 1 and `refresh_n` is 1, `memcs16_n` is 0 in the same cycle exactly when `cfg_wide` is 1 and `cfg_base <= la <= cfg_limit`.
- R3: After `bale` falls, `memcs16_n` keeps the decode taken in the last cycle `bale` was high, whatever `la` does, until `bale` rises again.
- R4: A command whose frozen decode missed the window gets no response: `sd_oe` stays 2'b00, `rdy` stays 1, and the RAM is unchanged.
- R5: With `cfg_zws`=0 and `cfg_wait`=N>0, `rdy` is 0 for exactly N cycles, starting in the cycle after the clock edge that first sees an accepted command.
- R6: With `cfg_zws`=1, `zws_n` is 0 for exactly one cycle, which is the cycle after the accepting edge, and `rdy` stays 1.
- R7: With `sa[0]`=0 and `sbhe_n`=0, a write stores `sd_in[15:0]` as a word, and a read drives the word with `sd_oe`=2'b11.
- R8: Single-byte lanes: with `sa[0]`=0 and `sbhe_n`=1, only the low byte is written or read, using `sd[7:0]` and `sd_oe`=2'b01. With `sa[0]`=1 and `sbhe_n`=0, only the high byte is written or read, using `sd[15:8]` and `sd_oe`=2'b10.
- R9: With `sa[0]`=1 and `sbhe_n`=1 (an 8-bit host reaching the odd byte), the high byte of the word is written from `sd_in[7:0]` and read back on `sd_out[7:0]` with `sd_oe`=2'b01.
- R10: While `refresh_n` is 0, the window is not selected. `sd_oe` stays 2'b00, `rdy` stays 1, `memcs16_n` is 1, and no write reaches the RAM.
- R11: With `cfg_wide`=0, `memcs16_n` stays 1 and reads and writes still complete.
- R12: `sd_oe` is non-zero only while `memr_n` is 0 in XFER or HOLD. It is 2'b00 during writes and in the cycle after the read command is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_base | input | 7 | Lowest upper-address value inside the window |
| cfg_limit | input | 7 | Highest upper-address value inside the window |
| cfg_wide | input | 1 | 1: advertise 16-bit capability |
| cfg_zws | input | 1 | 1: zero-wait response |
| cfg_wait | input | 4 | Not-ready cycles in slow mode |
| bale | input | 1 | Address-latch strobe |
| la | input | 7 | Unlatched upper address bits 23..17 |
| sa | input | 20 | Latched system address bits 19..0 |
| sbhe_n | input | 1 | High-byte enable, active low |
| memr_n | input | 1 | Memory read command, active low |
| memw_n | input | 1 | Memory write command, active low |
| refresh_n | input | 1 | Refresh cycle marker, active low |
| sd_in | input | 16 | Data from the bus |
| sd_out | output | 16 | Data to the bus |
| sd_oe | output | 2 | Lane drive enables {high, low} |
| memcs16_n | output | 1 | 16-bit capable, active low |
| zws_n | output | 1 | Zero-wait response, active low |
| rdy | output | 1 | Channel ready, low inserts wait states |

## Verification
The hardest case to reach is a refresh cycle that follows an address phase which did hit the window. If nothing gated it, the frozen decode would still select the board. The stimulus first runs a BALE phase inside the window, then lowers `refresh_n`, issues a write with all-ones data and then a read, and watches the lanes and ready for several cycles. A later normal read of the same word proves that no write slipped through. The bench also changes `la` to an out-of-window value straight after every strobe fall, so that every cycle exercises the frozen decode.

// File: rtl/isa_mslv_pkg.sv
package isa_mslv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_XFER,
        ST_HOLD
    } cyc_state_t;

    // Lane drive enables {high, low} for a read, from address bit 0 and the
    // active-low high-byte enable. An odd byte for an 8-bit host goes low.
    function automatic logic [1:0] lane_drive(input logic a0, input logic bhe_n);
        return {~bhe_n, (~a0) | bhe_n};
    endfunction

endpackage

// File: rtl/isa_addr_latch.sv
module isa_addr_latch #(
    parameter int LA_W   = 7,
    parameter int SA_W   = 20,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LA_W-1:0]   cfg_base,
    input  logic [LA_W-1:0]   cfg_limit,
    input  logic              cfg_wide,
    input  logic              bale,
    input  logic [LA_W-1:0]   la,
    input  logic [SA_W-1:0]   sa,
    input  logic              sbhe_n,
    input  logic              refresh_n,
    output logic              hit,
    output logic [ADDR_W-1:0] word_idx,
    output logic              a0,
    output logic              bhe_n,
    output logic              memcs16_n
);
    logic la_hit;
    logic hit_keep;
    logic [ADDR_W:0] low_keep;
    logic bhe_keep;

    // Early decode of the live upper address lines.
    assign la_hit = (la >= cfg_base) && (la <= cfg_limit);

    // Track the strobe: values update while it is high and freeze on its fall.
    always_ff @(posedge clk) begin
        if (rst) begin
            hit_keep <= 1'b0;
            low_keep <= '0;
            bhe_keep <= 1'b1;
        end else if (bale) begin
            hit_keep <= la_hit;
            low_keep <= sa[ADDR_W:0];
            bhe_keep <= sbhe_n;
        end
    end

    assign hit       = hit_keep;
    assign word_idx  = low_keep[ADDR_W:1];
    assign a0        = low_keep[0];
    assign bhe_n     = bhe_keep;
    assign memcs16_n = ~(cfg_wide & refresh_n & (bale ? la_hit : hit_keep));

endmodule

// File: rtl/isa_cycle_fsm.sv
module isa_cycle_fsm
    import isa_mslv_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_zws,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              bale,
    input  logic              hit,
    input  logic              memr_n,
    input  logic              memw_n,
    input  logic              refresh_n,
    output logic              rdy,
    output logic              zws_n,
    output logic              wr_en,
    output logic              rd_en
);
    cyc_state_t state, state_nx;
    logic [WAIT_W-1:0] cnt;
    logic zws_r;
    logic cmd_any;
    logic start;
    logic fast;

    assign cmd_any = ~memr_n | ~memw_n;
    assign start   = cmd_any & hit & refresh_n & ~bale;
    assign fast    = cfg_zws | (cfg_wait == '0);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = fast ? ST_XFER : ST_WAIT;
            ST_WAIT: begin
                if (!cmd_any)       state_nx = ST_IDLE;
                else if (cnt == 1)  state_nx = ST_XFER;
            end
            ST_XFER: state_nx = ST_HOLD;
            ST_HOLD: if (!cmd_any) state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            zws_r <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start) begin
                cnt   <= cfg_wait;
                zws_r <= cfg_zws;
            end else if (state == ST_WAIT) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    always_comb begin
        rdy   = (state != ST_WAIT);
        zws_n = ~((state == ST_XFER) & zws_r);
        wr_en = (state == ST_XFER) & ~memw_n & refresh_n;
        rd_en = ((state == ST_XFER) || (state == ST_HOLD)) & ~memr_n & refresh_n;
    end

    // R5: ready is only pulled low for a command present at the previous edge
    a_r5_wait_needs_cmd: assert property (@(posedge clk) disable iff (rst)
        !rdy |-> $past(cmd_any));

    // R6: zero-wait indication lasts one cycle
    a_r6_zws_single: assert property (@(posedge clk) disable iff (rst)
        !zws_n |=> zws_n);

endmodule

// File: rtl/isa_lane_ram.sv
module isa_lane_ram
    import isa_mslv_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] word_idx,
    input  logic              a0,
    input  logic              bhe_n,
    input  logic              hit,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [15:0]       sd_in,
    output logic [15:0]       sd_out,
    output logic [1:0]        sd_oe
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_lo [DEPTH];
    logic [7:0] mem_hi [DEPTH];
    logic we_lo, we_hi;
    logic [7:0] hi_src;
    logic [7:0] rd_lo, rd_hi;

    assign we_lo  = wr_en & ~a0;
    assign we_hi  = wr_en & (a0 | ~bhe_n);
    assign hi_src = (a0 & bhe_n) ? sd_in[7:0] : sd_in[15:8];

    always_ff @(posedge clk) begin
        if (we_lo) mem_lo[word_idx] <= sd_in[7:0];
        if (we_hi) mem_hi[word_idx] <= hi_src;
    end

    assign rd_lo  = mem_lo[word_idx];
    assign rd_hi  = mem_hi[word_idx];
    assign sd_out = {rd_hi, a0 ? rd_hi : rd_lo};
    assign sd_oe  = rd_en ? lane_drive(a0, bhe_n) : 2'b00;

    // R4: the RAM is written only for a cycle whose frozen decode hit
    a_r4_write_needs_hit: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> hit);

endmodule

// File: rtl/isa_mem_slave.sv
module isa_mem_slave
    import isa_mslv_pkg::*;
#(
    parameter int LA_W   = 7,
    parameter int SA_W   = 20,
    parameter int ADDR_W = 8,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LA_W-1:0]   cfg_base,
    input  logic [LA_W-1:0]   cfg_limit,
    input  logic              cfg_wide,
    input  logic              cfg_zws,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              bale,
    input  logic [LA_W-1:0]   la,
    input  logic [SA_W-1:0]   sa,
    input  logic              sbhe_n,
    input  logic              memr_n,
    input  logic              memw_n,
    input  logic              refresh_n,
    input  logic [15:0]       sd_in,
    output logic [15:0]       sd_out,
    output logic [1:0]        sd_oe,
    output logic              memcs16_n,
    output logic              zws_n,
    output logic              rdy
);
    logic              hit;
    logic [ADDR_W-1:0] word_idx;
    logic              a0;
    logic              bhe_n;
    logic              wr_en;
    logic              rd_en;

    isa_addr_latch #(.LA_W(LA_W), .SA_W(SA_W), .ADDR_W(ADDR_W)) u_latch (
        .clk(clk), .rst(rst),
        .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_wide(cfg_wide),
        .bale(bale), .la(la), .sa(sa), .sbhe_n(sbhe_n), .refresh_n(refresh_n),
        .hit(hit), .word_idx(word_idx), .a0(a0), .bhe_n(bhe_n),
        .memcs16_n(memcs16_n)
    );

    isa_cycle_fsm #(.WAIT_W(WAIT_W)) u_fsm (
        .clk(clk), .rst(rst),
        .cfg_zws(cfg_zws), .cfg_wait(cfg_wait),
        .bale(bale), .hit(hit),
        .memr_n(memr_n), .memw_n(memw_n), .refresh_n(refresh_n),
        .rdy(rdy), .zws_n(zws_n), .wr_en(wr_en), .rd_en(rd_en)
    );

    isa_lane_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .rst(rst),
        .word_idx(word_idx), .a0(a0), .bhe_n(bhe_n), .hit(hit),
        .wr_en(wr_en), .rd_en(rd_en),
        .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe)
    );

    // R10: nothing is driven onto the bus during refresh
    a_r10_refresh_silent: assert property (@(posedge clk) disable iff (rst)
        !refresh_n |-> (sd_oe == 2'b00));

    // R12: lanes are driven only under a read command
    a_r12_drive_needs_read: assert property (@(posedge clk) disable iff (rst)
        memr_n |-> (sd_oe == 2'b00));

endmodule

// File: tb/isa_mem_slave_tb_top.sv
module isa_mem_slave_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  cfg_base = 7'h10;
    logic [6:0]  cfg_limit = 7'h11;
    logic        cfg_wide = 1'b1;
    logic        cfg_zws = 1'b0;
    logic [3:0]  cfg_wait = 4'd3;
    logic        bale = 1'b0;
    logic [6:0]  la = '0;
    logic [19:0] sa = '0;
    logic        sbhe_n = 1'b1;
    logic        memr_n = 1'b1;
    logic        memw_n = 1'b1;
    logic        refresh_n = 1'b1;
    logic [15:0] sd_in = '0;
    logic [15:0] sd_out;
    logic [1:0]  sd_oe;
    logic        memcs16_n;
    logic        zws_n;
    logic        rdy;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    isa_mem_slave dut_i (
        .clk(clk), .rst(rst),
        .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_wide(cfg_wide),
        .cfg_zws(cfg_zws), .cfg_wait(cfg_wait),
        .bale(bale), .la(la), .sa(sa), .sbhe_n(sbhe_n),
        .memr_n(memr_n), .memw_n(memw_n), .refresh_n(refresh_n),
        .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe),
        .memcs16_n(memcs16_n), .zws_n(zws_n), .rdy(rdy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Address phase, then one command; all timing checks inside.
    task automatic bus_cycle(input bit wr, input logic [6:0] la_v,
                             input logic [19:0] sa_v, input logic bhe_v,
                             input logic [15:0] wd, input bit exp_cs,
                             input int exp_wait, input bit exp_zws,
                             input logic [15:0] exp_rd, input logic [1:0] exp_oe,
                             input string req);
        int waits = 0;
        bit zseen = 0;
        logic [15:0] mask;
        @(negedge clk);
        bale = 1'b1; la = la_v; sa = sa_v; sbhe_n = bhe_v;
        #1 chk(memcs16_n == !exp_cs, "R2", "live decode", memcs16_n, !exp_cs);
        @(negedge clk);
        bale = 1'b0; la = 7'h55;
        #1 chk(memcs16_n == !exp_cs, "R3", "held decode", memcs16_n, !exp_cs);
        @(negedge clk);
        if (wr) begin memw_n = 1'b0; sd_in = wd; end
        else memr_n = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            #1;
            if (!zws_n) zseen = 1;
            if (wr && sd_oe != 2'b00)
                chk(0, "R12", "drive during write", sd_oe, 0);
            if (!rdy) waits++;
            else break;
        end
        chk(waits == exp_wait, "R5", "not-ready cycles", waits, exp_wait);
        chk(zseen == exp_zws, "R6", "zero-wait seen", zseen, exp_zws);
        if (!wr) begin
            mask = {{8{exp_oe[1]}}, {8{exp_oe[0]}}};
            chk(sd_oe == exp_oe, req, "lane enables", sd_oe, exp_oe);
            chk((sd_out & mask) == (exp_rd & mask), req, "read data",
                sd_out & mask, exp_rd & mask);
        end
        @(negedge clk);
        memr_n = 1'b1; memw_n = 1'b1;
        #1 chk(sd_oe == 2'b00, "R12", "released", sd_oe, 0);
        chk(zws_n == 1'b1, "R6", "zero-wait ends", zws_n, 1);
    endtask

    // Command that must get no answer at all for several cycles.
    task automatic silent_cycle(input bit wr, input string req);
        @(negedge clk);
        if (wr) begin memw_n = 1'b0; sd_in = 16'hFFFF; end
        else memr_n = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            #1;
            chk(sd_oe == 2'b00 && rdy == 1'b1, req, "silent {oe,rdy}",
                {sd_oe, rdy}, 3'b001);
        end
        memr_n = 1'b1; memw_n = 1'b1;
    endtask

    task automatic t_reset;
        chk(memcs16_n == 1'b1, "R1", "memcs16_n", memcs16_n, 1);
        chk(zws_n == 1'b1, "R1", "zws_n", zws_n, 1);
        chk(rdy == 1'b1, "R1", "rdy", rdy, 1);
        chk(sd_oe == 2'b00, "R1", "sd_oe", sd_oe, 0);
    endtask

    task automatic t_word;
        bus_cycle(1, 7'h10, 20'h00004, 0, 16'h1234, 1, 3, 0, 16'h0, 2'b00, "R7");
        bus_cycle(0, 7'h10, 20'h00004, 0, 16'h0,    1, 3, 0, 16'h1234, 2'b11, "R7");
    endtask

    task automatic t_lanes;
        bus_cycle(1, 7'h11, 20'h00005, 0, 16'hAB00, 1, 3, 0, 16'h0, 2'b00, "R8");
        bus_cycle(1, 7'h11, 20'h00004, 1, 16'h00CD, 1, 3, 0, 16'h0, 2'b00, "R8");
        bus_cycle(0, 7'h10, 20'h00004, 0, 16'h0, 1, 3, 0, 16'hABCD, 2'b11, "R8");
        bus_cycle(0, 7'h10, 20'h00004, 1, 16'h0, 1, 3, 0, 16'h00CD, 2'b01, "R8");
        bus_cycle(0, 7'h10, 20'h00005, 0, 16'h0, 1, 3, 0, 16'hAB00, 2'b10, "R8");
    endtask

    task automatic t_odd8;
        bus_cycle(0, 7'h10, 20'h00005, 1, 16'h0, 1, 3, 0, 16'h00AB, 2'b01, "R9");
        bus_cycle(1, 7'h10, 20'h00005, 1, 16'h0077, 1, 3, 0, 16'h0, 2'b00, "R9");
        bus_cycle(0, 7'h10, 20'h00004, 0, 16'h0, 1, 3, 0, 16'h77CD, 2'b11, "R9");
    endtask

    task automatic t_zws;
        cfg_zws = 1'b1;
        bus_cycle(1, 7'h10, 20'h00008, 0, 16'h5AA5, 1, 0, 1, 16'h0, 2'b00, "R6");
        bus_cycle(0, 7'h10, 20'h00008, 0, 16'h0, 1, 0, 1, 16'h5AA5, 2'b11, "R6");
        cfg_zws = 1'b0;
        cfg_wait = 4'd1;
        bus_cycle(0, 7'h10, 20'h00008, 0, 16'h0, 1, 1, 0, 16'h5AA5, 2'b11, "R5");
        cfg_wait = 4'd3;
    endtask

    task automatic t_miss;
        @(negedge clk);
        bale = 1'b1; la = 7'h40; sa = 20'h00004; sbhe_n = 1'b0;
        #1 chk(memcs16_n == 1'b1, "R4", "no decode", memcs16_n, 1);
        @(negedge clk);
        bale = 1'b0;
        silent_cycle(1, "R4");
        silent_cycle(0, "R4");
        bus_cycle(0, 7'h10, 20'h00004, 0, 16'h0, 1, 3, 0, 16'h77CD, 2'b11, "R4");
    endtask

    task automatic t_refresh;
        @(negedge clk);
        bale = 1'b1; la = 7'h10; sa = 20'h00004; sbhe_n = 1'b0;
        @(negedge clk);
        bale = 1'b0; refresh_n = 1'b0;
        #1 chk(memcs16_n == 1'b1, "R10", "cs during refresh", memcs16_n, 1);
        silent_cycle(1, "R10");
        silent_cycle(0, "R10");
        refresh_n = 1'b1;
        bus_cycle(0, 7'h10, 20'h00004, 0, 16'h0, 1, 3, 0, 16'h77CD, 2'b11, "R10");
    endtask

    task automatic t_narrow;
        cfg_wide = 1'b0;
        bus_cycle(1, 7'h10, 20'h0000A, 1, 16'h0042, 0, 3, 0, 16'h0, 2'b00, "R11");
        bus_cycle(0, 7'h10, 20'h0000A, 1, 16'h0, 0, 3, 0, 16'h0042, 2'b01, "R11");
        cfg_wide = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1 t_reset();
        t_word();
        t_lanes();
        t_odd8();
        t_zws();
        t_miss();
        t_refresh();
        t_narrow();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule